// File: doc/BRIEF.md
# Audio Mode and Initialization Sequencer

This block is the control sequencer of a serial-audio effects processor. It merges pin and register requests for power-down and through routing, and it decides whether the serial output bus carries the processed stream, the raw input stream or a forced-low level. It also produces an output mute enable. That enable changes state only on rising edges of the output word clock, so each mute takes effect on a whole word.

Four events start one shared initialization: release of reset, release of power-down, return from through routing to normal operation, and a rising direct-mute request. The initialization holds a busy flag for a fixed number of input sample periods. While it runs, the output stays muted and an address counter writes zeros into every location of the delay memory. A new event during a running sequence restarts both counters. While power-down or through routing is in force, the sequencer stays idle.

Top module: `audio_mode_seq`

## Requirements
- R1: While `rst` is high, every output is 0: the serial outputs, `mute_en`, `pdn_active`, `bypass_sel`, `init_busy` and `mem_we`.
- R2: Power-down is in force when `pdn_pin_n` is 0 or `reg_pwr_on` is 0. Then `pdn_active` is 1 and `out_lrck`, `out_bck` and `out_sdata` are 0, whatever the through setting is.
- R3: Through routing is in force when `byp_pin_n` is 0 or `reg_run` is 0. Then `bypass_sel` is 1, and without power-down the outputs copy `in_lrck`, `in_bck` and `in_sdata` one clock later.
- R4: With neither mode in force, the outputs copy `core_lrck`, `core_bck` and `core_sdata` one clock later.
- R5: `mute_en` changes only on a rising edge of the synchronized `core_lrck`. At that edge it takes the value (direct mute OR `init_busy`). Edges are ignored while power-down is in force.
- R6: After a start, `init_busy` stays 1 through 127 rising edges of `in_lrck` and falls on the 128th (`INIT_SAMPLES`).
- R7: Each start writes `mem_wdata` = 0 with `mem_we` = 1 to addresses 0 up to DEPTH-1 in ascending order, one per clock, on consecutive clocks.
- R8: Deassertion of `rst` starts the initialization.
- R9: The end of power-down starts the initialization.
- R10: The end of through routing starts the initialization.
- R11: A 0-to-1 change of `reg_dmute` starts the initialization.
- R12: A start during a running sequence restarts the sample count and the clear address from zero.
- R13: While power-down or through routing is in force, `init_busy` and `mem_we` are 0 and start events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its release starts initialization |
| pdn_pin_n | input | 1 | Power-down pin, 0 requests power-down |
| byp_pin_n | input | 1 | Through pin, 0 requests through routing |
| reg_dmute | input | 1 | Register flag, 1 requests direct mute |
| reg_pwr_on | input | 1 | Register flag, 0 requests power-down |
| reg_run | input | 1 | Register flag, 0 requests through routing |
| in_lrck | input | 1 | Input word clock |
| in_bck | input | 1 | Input bit clock |
| in_sdata | input | 1 | Input serial data |
| core_lrck | input | 1 | Processed-path output word clock |
| core_bck | input | 1 | Processed-path bit clock |
| core_sdata | input | 1 | Processed-path serial data |
| out_lrck | output | 1 | Output word clock |
| out_bck | output | 1 | Output bit clock |
| out_sdata | output | 1 | Output serial data |
| mute_en | output | 1 | Word-aligned output mute |
| pdn_active | output | 1 | Power-down in force |
| bypass_sel | output | 1 | Through routing in force |
| init_busy | output | 1 | Initialization running |
| mem_we | output | 1 | Delay memory write enable |
| mem_addr | output | ADDR_W | Delay memory write address |
| mem_wdata | output | DATA_W | Delay memory write data (always zero) |

## Verification
The hardest case to reach from the ports is a start that arrives while a sequence is already running. The restart has to land both inside the short clear burst and, separately, in the middle of the sample window. The stimulus drops and raises the direct-mute flag again a few clocks after the first start, while the address counter is still moving. A later restart after 50 word periods checks that the busy window is counted again from zero. The word-clock tasks hold the clocks low around every trigger, so the exact boundary between the 127th and 128th sample edge can be sampled away from any edge.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef struct packed {
    logic pdn_n;
    logic byp_n;
    logic pwr_on;
    logic run;
    logic dmute;
    logic in_lrck;
    logic out_lrck;
  } ctl_bits_t;

  localparam ctl_bits_t CTL_IDLE = '{
    pdn_n: 1'b1, byp_n: 1'b1, pwr_on: 1'b1, run: 1'b1,
    dmute: 1'b0, in_lrck: 1'b0, out_lrck: 1'b0
  };

  typedef struct packed {
    logic lrck;
    logic bck;
    logic sdata;
  } ser_bus_t;

endpackage

// File: rtl/amc_sync.sv
module amc_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (STAGES <= 1) begin : g_single
    logic [WIDTH-1:0] stg;
    always_ff @(posedge clk) begin
      if (rst) stg <= RST_VAL;
      else     stg <= d;
    end
    assign q = stg;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] stg;
    always_ff @(posedge clk) begin
      if (rst) stg <= {STAGES{RST_VAL}};
      else     stg <= {stg[STAGES-2:0], d};
    end
    assign q = stg[STAGES-1];
  end

endmodule

// File: rtl/amc_mode_ctrl.sv
module amc_mode_ctrl
  import amc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pdn_pin_n,
  input  logic byp_pin_n,
  input  logic reg_dmute,
  input  logic reg_pwr_on,
  input  logic reg_run,
  input  logic in_lrck,
  input  logic core_lrck,
  input  logic busy,
  output logic pd_q,
  output logic byp_q,
  output logic mute_q,
  output logic in_rise,
  output logic out_rise,
  output logic start,
  output logic halt
);

  ctl_bits_t raw_c;
  ctl_bits_t syn_c;

  assign raw_c.pdn_n    = pdn_pin_n;
  assign raw_c.byp_n    = byp_pin_n;
  assign raw_c.pwr_on   = reg_pwr_on;
  assign raw_c.run      = reg_run;
  assign raw_c.dmute    = reg_dmute;
  assign raw_c.in_lrck  = in_lrck;
  assign raw_c.out_lrck = core_lrck;

  amc_sync #(
    .WIDTH  ($bits(ctl_bits_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_c),
    .q  (syn_c)
  );

  logic pd_req, byp_req;
  logic pd_d, byp_d, dm_d, in_d, out_d, boot;

  assign pd_req  = ~syn_c.pdn_n | ~syn_c.pwr_on;
  assign byp_req = ~syn_c.byp_n | ~syn_c.run;

  assign in_rise  = syn_c.in_lrck  & ~in_d;
  assign out_rise = syn_c.out_lrck & ~out_d;
  assign halt     = pd_q | byp_q;

  // any of the four entry events, masked while a stopping mode holds
  assign start = (boot
                  | (pd_d  & ~pd_q)
                  | (byp_d & ~byp_q)
                  | (syn_c.dmute & ~dm_d)) & ~halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q   <= 1'b0;
      byp_q  <= 1'b0;
      pd_d   <= 1'b0;
      byp_d  <= 1'b0;
      dm_d   <= 1'b0;
      in_d   <= 1'b0;
      out_d  <= 1'b0;
      boot   <= 1'b1;
      mute_q <= 1'b0;
    end else begin
      pd_q  <= pd_req;
      byp_q <= byp_req;
      pd_d  <= pd_q;
      byp_d <= byp_q;
      dm_d  <= syn_c.dmute;
      in_d  <= syn_c.in_lrck;
      out_d <= syn_c.out_lrck;
      boot  <= 1'b0;
      if (out_rise && !pd_q) mute_q <= syn_c.dmute | busy;
    end
  end

endmodule

// File: rtl/amc_init_seq.sv
module amc_init_seq #(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int INIT_SAMPLES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              halt,
  input  logic              in_rise,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int CNT_W = (INIT_SAMPLES > 1) ? $clog2(INIT_SAMPLES) : 1;
  localparam logic [CNT_W-1:0]  SAMP_LAST = CNT_W'(INIT_SAMPLES - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  logic [CNT_W-1:0]  samp_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              clr_q;

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      busy     <= 1'b0;
      samp_cnt <= '0;
      clr_q    <= 1'b0;
      addr_q   <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      samp_cnt <= '0;
      clr_q    <= 1'b1;
      addr_q   <= '0;
    end else begin
      if (busy && in_rise) begin
        if (samp_cnt == SAMP_LAST) begin
          busy     <= 1'b0;
          samp_cnt <= '0;
        end else begin
          samp_cnt <= samp_cnt + 1'b1;
        end
      end
      if (clr_q) begin
        if (addr_q == ADDR_LAST) clr_q  <= 1'b0;
        else                     addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign mem_we    = clr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = '0;

endmodule

// File: rtl/amc_out_mux.sv
module amc_out_mux
  import amc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pd,
  input  logic     byp,
  input  ser_bus_t in_bus,
  input  ser_bus_t core_bus,
  output ser_bus_t out_bus
);

  always_ff @(posedge clk) begin
    if (rst || pd) out_bus <= '0;
    else if (byp)  out_bus <= in_bus;
    else           out_bus <= core_bus;
  end

endmodule

// File: rtl/audio_mode_seq.sv
module audio_mode_seq
  import amc_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int INIT_SAMPLES = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_pin_n,
  input  logic              byp_pin_n,
  input  logic              reg_dmute,
  input  logic              reg_pwr_on,
  input  logic              reg_run,
  input  logic              in_lrck,
  input  logic              in_bck,
  input  logic              in_sdata,
  input  logic              core_lrck,
  input  logic              core_bck,
  input  logic              core_sdata,
  output logic              out_lrck,
  output logic              out_bck,
  output logic              out_sdata,
  output logic              mute_en,
  output logic              pdn_active,
  output logic              bypass_sel,
  output logic              init_busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic pd_w, byp_w, mute_w, in_rise_w, out_rise_w, start_w, halt_w, busy_w;
  ser_bus_t in_bus, core_bus, out_bus;

  amc_mode_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .pdn_pin_n (pdn_pin_n),
    .byp_pin_n (byp_pin_n),
    .reg_dmute (reg_dmute),
    .reg_pwr_on(reg_pwr_on),
    .reg_run   (reg_run),
    .in_lrck   (in_lrck),
    .core_lrck (core_lrck),
    .busy      (busy_w),
    .pd_q      (pd_w),
    .byp_q     (byp_w),
    .mute_q    (mute_w),
    .in_rise   (in_rise_w),
    .out_rise  (out_rise_w),
    .start     (start_w),
    .halt      (halt_w)
  );

  amc_init_seq #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .INIT_SAMPLES(INIT_SAMPLES)
  ) u_init (
    .clk      (clk),
    .rst      (rst),
    .start    (start_w),
    .halt     (halt_w),
    .in_rise  (in_rise_w),
    .busy     (busy_w),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  assign in_bus   = '{lrck: in_lrck,   bck: in_bck,   sdata: in_sdata};
  assign core_bus = '{lrck: core_lrck, bck: core_bck, sdata: core_sdata};

  amc_out_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .pd      (pd_w),
    .byp     (byp_w),
    .in_bus  (in_bus),
    .core_bus(core_bus),
    .out_bus (out_bus)
  );

  assign out_lrck   = out_bus.lrck;
  assign out_bck    = out_bus.bck;
  assign out_sdata  = out_bus.sdata;
  assign mute_en    = mute_w;
  assign pdn_active = pd_w;
  assign bypass_sel = byp_w;
  assign init_busy  = busy_w;

endmodule

// File: rtl/audio_mode_seq_chk.sv
module audio_mode_seq_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_lrck,
  input logic              in_bck,
  input logic              in_sdata,
  input logic              core_lrck,
  input logic              core_bck,
  input logic              core_sdata,
  input logic              out_lrck,
  input logic              out_bck,
  input logic              out_sdata,
  input logic              mute_en,
  input logic              pdn_active,
  input logic              bypass_sel,
  input logic              init_busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              in_rise,
  input logic              out_rise,
  input logic              start
);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |=> (!mute_en && !init_busy && !mem_we && !out_lrck && !out_bck && !out_sdata));

  a_r2_pdn_forces_low: assert property (@(posedge clk) disable iff (rst)
    pdn_active |=> (!out_lrck && !out_bck && !out_sdata));

  a_r3_through_copies_input: assert property (@(posedge clk) disable iff (rst)
    (bypass_sel && !pdn_active) |=>
      (out_lrck == $past(in_lrck) && out_bck == $past(in_bck) && out_sdata == $past(in_sdata)));

  a_r4_normal_copies_core: assert property (@(posedge clk) disable iff (rst)
    (!bypass_sel && !pdn_active) |=>
      (out_lrck == $past(core_lrck) && out_bck == $past(core_bck) && out_sdata == $past(core_sdata)));

  a_r5_mute_on_word_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(mute_en) |-> $past(out_rise));

  a_r5_busy_mutes_next_word: assert property (@(posedge clk) disable iff (rst)
    (init_busy && out_rise && !pdn_active) |=> mute_en);

  a_r6_busy_ends_on_sample: assert property (@(posedge clk) disable iff (rst)
    $fell(init_busy) |-> ($past(in_rise) || $past(pdn_active || bypass_sel)));

  a_r7_writes_zero: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == '0));

  a_r7_addr_ascends: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we) && !$past(start)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r12_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start |=> (init_busy && mem_we && mem_addr == '0));

  a_r13_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (pdn_active || bypass_sel) |=> (!init_busy && !mem_we));

endmodule

bind audio_mode_seq audio_mode_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_lrck   (in_lrck),
  .in_bck    (in_bck),
  .in_sdata  (in_sdata),
  .core_lrck (core_lrck),
  .core_bck  (core_bck),
  .core_sdata(core_sdata),
  .out_lrck  (out_lrck),
  .out_bck   (out_bck),
  .out_sdata (out_sdata),
  .mute_en   (mute_en),
  .pdn_active(pdn_active),
  .bypass_sel(bypass_sel),
  .init_busy (init_busy),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .in_rise   (in_rise_w),
  .out_rise  (out_rise_w),
  .start     (start_w)
);

// File: tb/audio_mode_seq_tb_top.sv
module audio_mode_seq_tb_top;

  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int NSAMP   = 128;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HALF_WC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn_pin_n = 1'b1, byp_pin_n = 1'b1;
  logic reg_dmute = 1'b0, reg_pwr_on = 1'b1, reg_run = 1'b1;
  logic in_lrck = 1'b0, in_bck = 1'b0, in_sdata = 1'b0;
  logic core_lrck = 1'b0, core_bck = 1'b0, core_sdata = 1'b0;
  logic out_lrck, out_bck, out_sdata, mute_en, pdn_active, bypass_sel, init_busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_mode_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_SAMPLES(NSAMP)) dut_i (
    .clk(clk), .rst(rst),
    .pdn_pin_n(pdn_pin_n), .byp_pin_n(byp_pin_n),
    .reg_dmute(reg_dmute), .reg_pwr_on(reg_pwr_on), .reg_run(reg_run),
    .in_lrck(in_lrck), .in_bck(in_bck), .in_sdata(in_sdata),
    .core_lrck(core_lrck), .core_bck(core_bck), .core_sdata(core_sdata),
    .out_lrck(out_lrck), .out_bck(out_bck), .out_sdata(out_sdata),
    .mute_en(mute_en), .pdn_active(pdn_active), .bypass_sel(bypass_sel),
    .init_busy(init_busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // delay memory stub with write-order tracking
  logic [DATA_W-1:0] mem [DEPTH];
  logic fill_req = 1'b0;
  int wr_cnt = 0;
  int seq_err = 0;
  logic [ADDR_W-1:0] last_addr = '0;

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(i + 1);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (mem_addr == '0) wr_cnt <= 1;
      else begin
        if (mem_addr != last_addr + ADDR_W'(1)) seq_err <= seq_err + 1;
        wr_cnt <= wr_cnt + 1;
      end
      last_addr <= mem_addr;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic refill();
    fill_req = 1'b1;
    step(1);
    fill_req = 1'b0;
    step(1);
  endtask

  function automatic int nonzero_words();
    int nz = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != '0) nz++;
    return nz;
  endfunction

  task automatic in_sample();
    in_lrck = 1'b1; step(HALF_WC);
    in_lrck = 1'b0; step(HALF_WC);
  endtask

  task automatic out_word();
    core_lrck = 1'b1; step(HALF_WC);
    core_lrck = 1'b0; step(HALF_WC);
  endtask

  task automatic check_clear(input string req);
    step(DEPTH + 10);
    chk({req, " R7 memory zeroed"}, nonzero_words(), 0);
    chk({req, " R7 write count"}, wr_cnt, DEPTH);
    chk({req, " R7 write order"}, seq_err, 0);
  endtask

  task automatic run_samples(input int n);
    for (int k = 0; k < n; k++) in_sample();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    refill();
    step(4);
    // R1 reset state
    chk("R1 out", {out_lrck, out_bck, out_sdata}, 0);
    chk("R1 flags", {mute_en, pdn_active, bypass_sel, init_busy, mem_we}, 0);

    // R8 reset release starts init
    rst = 1'b0;
    step(6);
    chk("R8 busy after reset release", init_busy, 1);
    check_clear("R8");
    chk("R5 mute waits for word edge", mute_en, 0);
    out_word();
    chk("R5 busy mutes at word edge", mute_en, 1);

    // R6 window length
    run_samples(NSAMP - 1);
    chk("R6 busy after 127 samples", init_busy, 1);
    in_sample();
    chk("R6 idle after 128 samples", init_busy, 0);
    out_word();
    chk("R5 unmute at word edge", mute_en, 0);

    // R11 direct mute rise starts init; R5 alignment
    refill();
    reg_dmute = 1'b1;
    step(10);
    chk("R11 busy on mute rise", init_busy, 1);
    chk("R5 mute not before word edge", mute_en, 0);
    check_clear("R11");
    out_word();
    chk("R5 mute entry at word edge", mute_en, 1);
    reg_dmute = 1'b0;
    run_samples(NSAMP);
    chk("R6 idle after window", init_busy, 0);
    step(20);
    chk("R5 mute held until word edge", mute_en, 1);
    out_word();
    chk("R5 mute release at word edge", mute_en, 0);

    // R12 restart during clear and during window
    refill();
    reg_dmute = 1'b1; step(20);
    reg_dmute = 1'b0; step(6);
    reg_dmute = 1'b1;
    check_clear("R12 mid-clear restart");
    run_samples(50);
    reg_dmute = 1'b0; step(6);
    reg_dmute = 1'b1; step(10);
    run_samples(NSAMP - 1);
    chk("R12 window restarted", init_busy, 1);
    in_sample();
    chk("R12 window ends after restart", init_busy, 0);
    reg_dmute = 1'b0;
    step(10);

    // R13 / R9 power-down
    reg_pwr_on = 1'b0;
    step(10);
    chk("R2 flag power-down", pdn_active, 1);
    reg_dmute = 1'b1; step(10);
    chk("R13 mute rise ignored in power-down", init_busy, 0);
    refill();
    step(DEPTH + 10);
    chk("R13 no clear in power-down", nonzero_words(), DEPTH);
    reg_dmute = 1'b0; step(10);
    reg_pwr_on = 1'b1;
    step(6);
    chk("R9 busy after power-down release", init_busy, 1);
    check_clear("R9");
    pdn_pin_n = 1'b0;
    step(6);
    chk("R13 power-down aborts init", init_busy, 0);
    pdn_pin_n = 1'b1;
    step(DEPTH + 10);
    run_samples(NSAMP);

    // R10 through exit
    byp_pin_n = 1'b0;
    step(10);
    chk("R3 pin through", bypass_sel, 1);
    chk("R13 idle in through", init_busy, 0);
    refill();
    byp_pin_n = 1'b1;
    step(6);
    chk("R10 busy after through exit", init_busy, 1);
    check_clear("R10");

    // R2/R3/R4 routing sweep
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 64; p++) begin
        logic pd_e, byp_e;
        logic [2:0] o_e;
        pdn_pin_n  = m[0];
        reg_pwr_on = m[1];
        byp_pin_n  = m[2];
        reg_run    = m[3];
        {in_lrck, in_bck, in_sdata}       = p[2:0];
        {core_lrck, core_bck, core_sdata} = p[5:3];
        step(6);
        pd_e  = !m[0] || !m[1];
        byp_e = !m[2] || !m[3];
        o_e   = pd_e ? 3'b000 : (byp_e ? p[2:0] : p[5:3]);
        chk(pd_e ? "R2 routing" : (byp_e ? "R3 routing" : "R4 routing"),
            {pdn_active, bypass_sel, out_lrck, out_bck, out_sdata},
            {pd_e, byp_e, o_e});
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule